// File: doc/BRIEF.md
# Low-Power Mode Decoder with Sticky Entry Flags

This block chooses the low-power state a device enters when its processor raises a deep-sleep request. Software programs a 3-bit mode-select field and a backup-memory retention bit through a small write/read register port. On the rising edge of the request the block decodes those two settings into one of four stop levels, standby or shutdown. It stays in that state until a wakeup event returns it to run. The chosen state is given as a one-hot vector.

Two sticky flags record that a stop level or standby was entered. One write of 1 to a single clear bit drops both flags. The stop flag and all configuration belong to the system-reset domain. The standby flag belongs to the power-on-reset domain, so it survives a system reset. Both reset inputs are asynchronous and active-low, and each is released through its own synchronizer.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output shows run (bit 0 only), both flags are 0 and every register reads 0.
- R2: On a deep-sleep rising edge in run, mode-select values 0, 1, 2 and 3 enter stop levels 0 to 3, shown on mode bits 1 to 4.
- R3: Mode-select values 4 and 5 enter standby (mode bit 5).
- R4: Mode-select values 6 and 7 enter shutdown (mode bit 6) when retention is 0, and standby when retention is 1.
- R5: Exactly one mode bit is high in every cycle.
- R6: The mode is sampled only at the rising edge of the request while in run. A held request, a new rising edge or a mode-select write made while in a low-power state leaves the mode unchanged.
- R7: A wakeup event in any low-power state returns the mode to run at the next clock. The flags keep their values.
- R8: Entering any stop level sets the stop flag, and entering standby sets the standby flag. Both take effect on the same edge as the mode change. Shutdown sets neither flag.
- R9: Writing 1 to bit 0 at address 3 clears both flags in one cycle. If a flag is set in the same cycle, the set wins. Bit 0 always reads 0, bit 1 reads the stop flag and bit 2 reads the standby flag.
- R10: A system reset clears the mode, the configuration and the stop flag, but keeps the standby flag. A power-on reset clears everything.
- R11: Address 0 bits 2:0 hold mode-select, address 1 bit 0 holds retention and address 2 bit 0 selects the switching regulator (1) or the linear regulator (0). A retention write is ignored while the stored selection is 1.
- R12: After a reset input is released, the block stays in reset for SYNC_STAGES clock edges, and register writes in that window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, asynchronous, active-low |
| sys_rst_ni | input | 1 | System reset, asynchronous, active-low |
| sleep_req_i | input | 1 | Deep-sleep request from the processor |
| wake_evt_i | input | 1 | Wakeup event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| mode_onehot_o | output | 7 | Current mode: run, stop 0 to 3, standby, shutdown |
| stop_flag_o | output | 1 | Sticky stop-entered flag |
| sby_flag_o | output | 1 | Sticky standby-entered flag |

## Verification
Some properties are checked on every cycle: the one-hot mode output, the return to run after a wakeup, the hold of a low-power state without one, the setting and clearing of the stop flag, the lock on retention writes, and the standby flag holding while system reset is asserted. Other behaviour needs the bench's scenarios and its cycle-level reference model:
- the full decode table, including both retention cases of the 11x values;
- the rule that set wins over clear;
- the survival of the standby flag across a system-reset pulse followed by a power-on reset;
- the writes that are lost inside the reset-release window.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int SEL_W  = 3;
  localparam int MODE_N = 7;

  typedef enum logic [2:0] {
    LPM_RUN      = 3'd0,
    LPM_STOP0    = 3'd1,
    LPM_STOP1    = 3'd2,
    LPM_STOP2    = 3'd3,
    LPM_STOP3    = 3'd4,
    LPM_STANDBY  = 3'd5,
    LPM_SHUTDOWN = 3'd6
  } lp_mode_e;

  // Mode-select decode; retention turns the 11x shutdown codes into standby.
  function automatic lp_mode_e lpm_decode(logic [SEL_W-1:0] sel, logic keep_bkp);
    lp_mode_e m;
    if (!sel[2])      m = lp_mode_e'({1'b0, sel[1:0]} + 3'd1);
    else if (!sel[1]) m = LPM_STANDBY;
    else if (keep_bkp) m = LPM_STANDBY;
    else              m = LPM_SHUTDOWN;
    return m;
  endfunction

  function automatic logic lpm_is_stop(lp_mode_e m);
    return (m == LPM_STOP0) || (m == LPM_STOP1) || (m == LPM_STOP2) || (m == LPM_STOP3);
  endfunction

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs import lpm_pkg::*; #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stop_flag_i,
  input  logic              sby_flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  mode_sel_o,
  output logic              keep_bkp_o,
  output logic              clr_o
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BKP  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SUP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             keep_q, keep_d;
  logic             sw_q, sw_d;
  logic             sel_en, keep_req, keep_en, sw_en;

  always_comb begin
    sel_en   = wr_i && (addr_i == A_MODE);
    keep_req = wr_i && (addr_i == A_BKP);
    keep_en  = keep_req && !sw_q;
    sw_en    = wr_i && (addr_i == A_SUP);
    sel_d    = wdata_i[SEL_W-1:0];
    keep_d   = wdata_i[0];
    sw_d     = wdata_i[0];
    clr_o    = wr_i && (addr_i == A_STAT) && wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      keep_q <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      if (sel_en)  sel_q  <= sel_d;
      if (keep_en) keep_q <= keep_d;
      if (sw_en)   sw_q   <= sw_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE:  rdata_o[SEL_W-1:0] = sel_q;
      A_BKP:   rdata_o[0] = keep_q;
      A_SUP:   rdata_o[0] = sw_q;
      default: rdata_o[2:1] = {sby_flag_i, stop_flag_i};
    endcase
  end

  assign mode_sel_o = sel_q;
  assign keep_bkp_o = keep_q;

  // R11: retention is locked while the switching regulator is selected
  a_r11_keep_locked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_req && sw_q) |=> $stable(keep_q));

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm import lpm_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             wake_evt_i,
  input  logic [SEL_W-1:0] mode_sel_i,
  input  logic             keep_bkp_i,
  output logic [MODE_N-1:0] mode_onehot_o,
  output logic             enter_stop_o,
  output logic             enter_sby_o
);

  lp_mode_e mode_q, mode_d, target;
  logic     sleep_q;
  logic     rise, mode_en;

  always_comb begin
    rise         = sleep_req_i && !sleep_q;
    target       = lpm_decode(mode_sel_i, keep_bkp_i);
    mode_d       = mode_q;
    mode_en      = 1'b0;
    enter_stop_o = 1'b0;
    enter_sby_o  = 1'b0;
    if (mode_q == LPM_RUN) begin
      if (rise) begin
        mode_en      = 1'b1;
        mode_d       = target;
        enter_stop_o = lpm_is_stop(target);
        enter_sby_o  = (target == LPM_STANDBY);
      end
    end else if (wake_evt_i) begin
      mode_en = 1'b1;
      mode_d  = LPM_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= LPM_RUN;
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= sleep_req_i;
      if (mode_en) mode_q <= mode_d;
    end
  end

  generate
    for (genvar i = 0; i < MODE_N; i++) begin : g_hot
      assign mode_onehot_o[i] = (mode_q == lp_mode_e'(i));
    end
  endgenerate

  // R7: wakeup returns to run
  a_r7_wake_to_run : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != LPM_RUN && wake_evt_i) |=> (mode_q == LPM_RUN));
  // R6: without wakeup a low-power state is held
  a_r6_hold_lowpower : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != LPM_RUN && !wake_evt_i) |=> $stable(mode_q));

endmodule

// File: rtl/lpm_status_flags.sv
module lpm_status_flags (
  input  logic clk_i,
  input  logic sys_rst_ni,
  input  logic por_rst_ni,
  input  logic enter_stop_i,
  input  logic enter_sby_i,
  input  logic clr_i,
  output logic stop_flag_o,
  output logic sby_flag_o
);

  logic stop_q, stop_d, stop_en;
  logic sby_q, sby_d, sby_en;
  logic sby_set, sby_clr;

  always_comb begin
    stop_en = enter_stop_i || clr_i;
    stop_d  = enter_stop_i;
    sby_set = enter_sby_i && sys_rst_ni;
    sby_clr = clr_i && sys_rst_ni;
    sby_en  = sby_set || sby_clr;
    sby_d   = sby_set;
  end

  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni)  stop_q <= 1'b0;
    else if (stop_en) stop_q <= stop_d;
  end

  always_ff @(posedge clk_i or negedge por_rst_ni) begin
    if (!por_rst_ni) sby_q <= 1'b0;
    else if (sby_en) sby_q <= sby_d;
  end

  assign stop_flag_o = stop_q;
  assign sby_flag_o  = sby_q;

  // R8: a stop entry raises the stop flag
  a_r8_stop_sets : assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    enter_stop_i |=> stop_q);
  // R9: clear without a simultaneous set drops the stop flag
  a_r9_clear_stop : assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (clr_i && !enter_stop_i) |=> !stop_q);
  // R10: standby flag holds while system reset is asserted
  a_r10_sby_kept : assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    !sys_rst_ni |=> $stable(sby_q));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl import lpm_pkg::*; #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              sys_rst_ni,
  input  logic              sleep_req_i,
  input  logic              wake_evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [MODE_N-1:0] mode_onehot_o,
  output logic              stop_flag_o,
  output logic              sby_flag_o
);

  logic             sys_arst_n;
  logic             por_rst_n, sys_rst_n;
  logic [SEL_W-1:0] mode_sel;
  logic             keep_bkp, clr;
  logic             enter_stop, enter_sby;

  assign sys_arst_n = por_ni & sys_rst_ni;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk_i(clk_i), .arst_ni(por_ni), .rst_no(por_rst_n));

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk_i(clk_i), .arst_ni(sys_arst_n), .rst_no(sys_rst_n));

  lpm_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .stop_flag_i(stop_flag_o),
    .sby_flag_i (sby_flag_o),
    .rdata_o    (reg_rdata_o),
    .mode_sel_o (mode_sel),
    .keep_bkp_o (keep_bkp),
    .clr_o      (clr)
  );

  lpm_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (sys_rst_n),
    .sleep_req_i  (sleep_req_i),
    .wake_evt_i   (wake_evt_i),
    .mode_sel_i   (mode_sel),
    .keep_bkp_i   (keep_bkp),
    .mode_onehot_o(mode_onehot_o),
    .enter_stop_o (enter_stop),
    .enter_sby_o  (enter_sby)
  );

  lpm_status_flags u_flags (
    .clk_i       (clk_i),
    .sys_rst_ni  (sys_rst_n),
    .por_rst_ni  (por_rst_n),
    .enter_stop_i(enter_stop),
    .enter_sby_i (enter_sby),
    .clr_i       (clr),
    .stop_flag_o (stop_flag_o),
    .sby_flag_o  (sby_flag_o)
  );

  // R5: exactly one mode bit active
  a_r5_onehot : assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    $countones(mode_onehot_o) == 1);

endmodule

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int SYNC   = 2;

  logic clk = 1'b0;
  logic por_n, sys_n, sleep, wake, wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [6:0] mode_oh;
  logic stop_f, sby_f;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 0;
  bit done   = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  lpm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .por_ni(por_n), .sys_rst_ni(sys_n), .sleep_req_i(sleep),
    .wake_evt_i(wake), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mode_onehot_o(mode_oh), .stop_flag_o(stop_f),
    .sby_flag_o(sby_f));

  // behavioural reference model
  int m_state = 0, m_sel = 0, cnt_por = 0, cnt_sys = 0;
  bit m_stop = 0, m_sby = 0, m_keep = 0, m_sw = 0, m_prev = 0;

  function automatic int decode(int sel, bit keep);
    if (sel < 4) return sel + 1;
    if (sel < 6) return 5;
    return keep ? 5 : 6;
  endfunction

  always @(posedge clk or negedge por_n or negedge sys_n) begin
    if (!por_n) begin
      cnt_por = 0; cnt_sys = 0; m_sby = 0;
      m_state = 0; m_stop = 0; m_sel = 0; m_keep = 0; m_sw = 0; m_prev = 0;
    end else if (!sys_n) begin
      if (clk && cnt_por < SYNC) cnt_por++;
      cnt_sys = 0;
      m_state = 0; m_stop = 0; m_sel = 0; m_keep = 0; m_sw = 0; m_prev = 0;
    end else if (clk) begin
      bit por_act, sys_act, rise, clr;
      int tgt;
      por_act = (cnt_por >= SYNC);
      sys_act = (cnt_sys >= SYNC);
      if (!por_act) cnt_por++;
      if (!sys_act) cnt_sys++;
      if (sys_act) begin
        rise = sleep && !m_prev;
        clr  = wr && addr == 3 && wdata[0];
        tgt  = decode(m_sel, m_keep);
        if (m_state == 0) begin
          if (rise) begin
            m_state = tgt;
            if (tgt >= 1 && tgt <= 4) m_stop = 1; else if (clr) m_stop = 0;
            if (tgt == 5) m_sby = 1; else if (clr && por_act) m_sby = 0;
          end else if (clr) begin
            m_stop = 0; if (por_act) m_sby = 0;
          end
        end else begin
          if (wake) m_state = 0;
          if (clr) begin m_stop = 0; if (por_act) m_sby = 0; end
        end
        if (wr) begin
          case (addr)
            0: m_sel = wdata & 7;
            1: if (!m_sw) m_keep = wdata[0];
            2: m_sw = wdata[0];
            default: ;
          endcase
        end
        m_prev = sleep;
      end
    end
  end

  function automatic logic [DATA_W-1:0] exp_rd(int a);
    logic [DATA_W-1:0] v = '0;
    case (a)
      0: v = DATA_W'(m_sel);
      1: v[0] = m_keep;
      2: v[0] = m_sw;
      default: begin v[1] = m_stop; v[2] = m_sby; end
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (chk_en && !done) begin
      logic [6:0] eo;
      eo = 7'(1 << m_state);
      checks++;
      if (mode_oh !== eo) begin
        fails++;
        $display("FAIL %s mode actual %b expected %b", cur_req, mode_oh, eo);
      end
      checks++;
      if ($countones(mode_oh) != 1) begin  // R5
        fails++;
        $display("FAIL R5 onehot actual %b expected one bit", mode_oh);
      end
      checks++;
      if (stop_f !== m_stop || sby_f !== m_sby) begin
        fails++;
        $display("FAIL %s flags actual stop=%b sby=%b expected stop=%b sby=%b",
                 cur_req, stop_f, sby_f, m_stop, m_sby);
      end
      checks++;
      if (rdata !== exp_rd(int'(addr))) begin
        fails++;
        $display("FAIL %s rdata@%0d actual %h expected %h", cur_req, addr, rdata, exp_rd(int'(addr)));
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wreg(int a, int d);
    wr = 1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    step();
    wr = 0; addr = 2'd3;
  endtask

  task automatic peek(int a);
    addr = ADDR_W'(a); step(); addr = 2'd3;
  endtask

  task automatic do_sleep();
    sleep = 1; step(3); sleep = 0; step();
  endtask

  task automatic do_wake();
    wake = 1; step(); wake = 0; step();
  endtask

  task automatic clear_flags();
    wreg(3, 1); step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    por_n = 0; sys_n = 0; sleep = 0; wake = 0; wr = 0; addr = 2'd3; wdata = '0;
    step(3);
    chk_en = 1;
    cur_req = "R1";
    por_n = 1; sys_n = 1;
    step(5);
    for (int a = 0; a < 4; a++) peek(a);

    cur_req = "R11";
    wreg(2, 1); wreg(1, 1); peek(1);
    wreg(2, 0); wreg(1, 1); peek(1);
    wreg(1, 0); peek(1);

    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      wreg(0, s); do_sleep(); peek(3); do_wake(); clear_flags();
    end

    cur_req = "R3";
    for (int s = 4; s < 6; s++) begin
      wreg(0, s); do_sleep(); do_wake(); clear_flags();
    end

    cur_req = "R4";
    for (int k = 0; k < 2; k++) begin
      wreg(1, k);
      for (int s = 6; s < 8; s++) begin
        wreg(0, s); do_sleep(); do_wake(); clear_flags();
      end
    end
    wreg(1, 0);

    cur_req = "R8";
    wreg(0, 7); do_sleep(); peek(3); do_wake();
    wreg(0, 2); do_sleep(); do_wake();
    wreg(0, 4); do_sleep(); do_wake();

    cur_req = "R6";
    wreg(0, 1); do_sleep();
    wreg(0, 5); do_sleep(); sleep = 1; step(4); sleep = 0; step();

    cur_req = "R7";
    do_wake(); step(2);

    cur_req = "R9";
    peek(3); wreg(3, 1); peek(3);
    wreg(0, 0);
    sleep = 1; wr = 1; addr = 2'd3; wdata = 8'h01; step();
    wr = 0; step(2); sleep = 0; step(); do_wake(); peek(3);
    wreg(3, 1); peek(3);

    cur_req = "R10";
    wreg(0, 4); do_sleep(); do_wake(); wreg(0, 3); do_sleep();
    sys_n = 0; step(3); sys_n = 1; step(4);
    for (int a = 0; a < 4; a++) peek(a);
    por_n = 0; step(2); por_n = 1; step(4); peek(3);

    cur_req = "R12";
    wreg(0, 5); do_sleep(); do_wake();
    sys_n = 0; step(2); sys_n = 1;
    wreg(0, 6); wreg(3, 1);
    step(3); peek(0); peek(3);
    wreg(0, 2); peek(0); do_sleep(); do_wake();

    step(3);
    done = 1;
    summary();
    $finish;
  end

endmodule